// File: doc/BRIEF.md
# ADC Channel Compare Interrupt Unit

This block is the interrupt logic that sits beside one channel of an analog-to-digital converter. Each time the converter pulses its conversion-done strobe, the block looks at the 12-bit signed two's complement result. Depending on the selected event mode, it sets a channel flag on every finished conversion, or only when the result is strictly below or strictly above a programmed signed threshold. While the flag is set and a non-zero priority level is programmed, the block drives a registered interrupt request with that level.

Software reaches the block through a byte-wide register port with four locations. Location 0 is the control byte: event mode in bits [3:2] and level in bits [1:0]. Location 1 holds the flag in bit 0. Location 2 is the threshold low byte and location 3 is the threshold high part. The flag clears when software writes a one to it, or when the interrupt controller acknowledges this channel's vector. A flag-setting event always beats a clear that lands in the same cycle.

Top module: `adc_cmp_irq`

## Requirements
- R1: After reset, the control byte, flag, threshold, read data, irq_req and irq_lvl are all zero.
- R2: Location 0 reads back {4'b0, mode[1:0], level[1:0]}; bits [7:4] are ignored on write and read as zero.
- R3: With mode 00, a conversion_done pulse sets the flag on the next clock edge, whatever the result.
- R4: With mode 01, a conversion sets the flag only when the signed result is strictly less than the signed threshold.
- R5: With mode 11, a conversion sets the flag only when the signed result is strictly greater than the signed threshold.
- R6: A conversion that misses the compare condition, or any cycle with no conversion and no clear, leaves the flag unchanged.
- R7: With mode 10 (reserved), hardware never sets the flag.
- R8: Writing location 1 with bit 0 = 1 clears the flag; writing bit 0 = 0 has no effect; bits [7:1] read as zero.
- R9: A vec_ack pulse clears the flag on the next edge.
- R10: When a set event and a clear (write-one or vec_ack) occur in the same cycle, the flag ends up set.
- R11: A write to location 2 is only staged. A write to location 3 commits {wdata[3:0], staged low byte} as the 12-bit threshold in one step. Locations 2 and 3 read the committed value, with location 3 bits [7:4] read as zero.
- R12: irq_req equals (flag AND level != 0) delayed by one clock, and irq_lvl equals the level delayed by one clock.
- R13: bus_rdata shows the location addressed in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register location |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| conv_done | input | 1 | One-cycle conversion finished strobe |
| conv_result | input | 12 | Signed conversion result |
| vec_ack | input | 1 | Vector acknowledge from interrupt controller |
| irq_req | output | 1 | Registered interrupt request |
| irq_lvl | output | 2 | Registered priority level |

## Verification
The two functions that can land in the same cycle are the flag-setting event from a finished conversion and a clear, which comes either from a software write-one or from a vector acknowledge. The bench first sets the flag, then drives conversion_done in complete mode together with a write of one to location 1, and repeats this with vec_ack. The flag is read back after each case and must still be one. Each clear is also applied alone, without a conversion, to confirm it removes the flag when nothing competes with it.

// File: rtl/adc_cmp_pkg.sv
package adc_cmp_pkg;
  typedef enum logic [1:0] {
    EVT_DONE  = 2'b00,
    EVT_BELOW = 2'b01,
    EVT_RSVD  = 2'b10,
    EVT_ABOVE = 2'b11
  } evt_mode_t;

  localparam logic [1:0] LOC_CTRL  = 2'd0;
  localparam logic [1:0] LOC_FLAG  = 2'd1;
  localparam logic [1:0] LOC_THRLO = 2'd2;
  localparam logic [1:0] LOC_THRHI = 2'd3;
endpackage

// File: rtl/adc_cmp_regs.sv
module adc_cmp_regs
  import adc_cmp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        addr,
  input  logic              wr,
  input  logic [BUS_W-1:0]  wdata,
  input  logic              flag,
  output logic [BUS_W-1:0]  rdata,
  output evt_mode_t         mode,
  output logic [LVL_W-1:0]  lvl,
  output logic [DATA_W-1:0] thr,
  output logic              flag_w1c
);
  localparam int HI_W = DATA_W - BUS_W;

  logic [BUS_W-1:0] lo_stage;
  logic [BUS_W-1:0] rd_next;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode     <= EVT_DONE;
      lvl      <= '0;
      thr      <= '0;
      lo_stage <= '0;
    end else if (wr) begin
      case (addr)
        LOC_CTRL:  begin
          mode <= evt_mode_t'(wdata[LVL_W+1:LVL_W]);
          lvl  <= wdata[LVL_W-1:0];
        end
        LOC_THRLO: lo_stage <= wdata;
        LOC_THRHI: thr <= {wdata[HI_W-1:0], lo_stage};
        default:   ;
      endcase
    end
  end

  assign flag_w1c = wr && (addr == LOC_FLAG) && wdata[0];

  always_comb begin
    rd_next = '0;
    case (addr)
      LOC_CTRL:  rd_next[LVL_W+1:0] = {mode, lvl};
      LOC_FLAG:  rd_next[0] = flag;
      LOC_THRLO: rd_next = thr[BUS_W-1:0];
      LOC_THRHI: rd_next[HI_W-1:0] = thr[DATA_W-1:BUS_W];
      default:   rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_next;
  end
endmodule

// File: rtl/adc_cmp_event.sv
module adc_cmp_event
  import adc_cmp_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              conv_done,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] thr,
  input  evt_mode_t         mode,
  output logic              set_evt
);
  logic lt, gt;

  assign lt = $signed(result) < $signed(thr);
  assign gt = $signed(result) > $signed(thr);

  always_comb begin
    case (mode)
      EVT_DONE:  set_evt = conv_done;
      EVT_BELOW: set_evt = conv_done && lt;
      EVT_ABOVE: set_evt = conv_done && gt;
      default:   set_evt = 1'b0;
    endcase
  end
endmodule

// File: rtl/adc_cmp_flag.sv
module adc_cmp_flag #(
  parameter int LVL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_evt,
  input  logic             flag_w1c,
  input  logic             vec_ack,
  input  logic [LVL_W-1:0] lvl,
  output logic             flag,
  output logic             irq_req,
  output logic [LVL_W-1:0] irq_lvl
);
  always_ff @(posedge clk) begin
    if (rst) begin
      flag    <= 1'b0;
      irq_req <= 1'b0;
      irq_lvl <= '0;
    end else begin
      if (set_evt)                  flag <= 1'b1;
      else if (flag_w1c || vec_ack) flag <= 1'b0;
      irq_req <= flag && (lvl != '0);
      irq_lvl <= lvl;
    end
  end
endmodule

// File: rtl/adc_cmp_irq.sv
module adc_cmp_irq
  import adc_cmp_pkg::*;
#(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8,
  parameter int LVL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        bus_addr,
  input  logic              bus_wr,
  input  logic [BUS_W-1:0]  bus_wdata,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] conv_result,
  input  logic              vec_ack,
  output logic              irq_req,
  output logic [LVL_W-1:0]  irq_lvl
);
  evt_mode_t         mode;
  logic [LVL_W-1:0]  lvl;
  logic [DATA_W-1:0] thr;
  logic              flag_q;
  logic              flag_w1c;
  logic              set_evt;

  adc_cmp_regs #(.DATA_W(DATA_W), .BUS_W(BUS_W), .LVL_W(LVL_W)) u_regs (
    .clk(clk), .rst(rst), .addr(bus_addr), .wr(bus_wr), .wdata(bus_wdata),
    .flag(flag_q), .rdata(bus_rdata), .mode(mode), .lvl(lvl), .thr(thr),
    .flag_w1c(flag_w1c)
  );

  adc_cmp_event #(.DATA_W(DATA_W)) u_evt (
    .conv_done(conv_done), .result(conv_result), .thr(thr), .mode(mode),
    .set_evt(set_evt)
  );

  adc_cmp_flag #(.LVL_W(LVL_W)) u_flag (
    .clk(clk), .rst(rst), .set_evt(set_evt), .flag_w1c(flag_w1c),
    .vec_ack(vec_ack), .lvl(lvl), .flag(flag_q), .irq_req(irq_req),
    .irq_lvl(irq_lvl)
  );
endmodule

// File: rtl/adc_cmp_irq_chk.sv
module adc_cmp_irq_chk #(
  parameter int DATA_W = 12,
  parameter int BUS_W  = 8,
  parameter int LVL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        bus_addr,
  input logic              bus_wr,
  input logic [BUS_W-1:0]  bus_wdata,
  input logic [BUS_W-1:0]  bus_rdata,
  input logic              conv_done,
  input logic [DATA_W-1:0] conv_result,
  input logic              vec_ack,
  input logic              irq_req,
  input logic [LVL_W-1:0]  irq_lvl,
  input logic [1:0]        mode,
  input logic [LVL_W-1:0]  lvl,
  input logic [DATA_W-1:0] thr,
  input logic              flag_q
);
  logic wr_one;
  assign wr_one = bus_wr && (bus_addr == 2'd1) && bus_wdata[0];

  // R2
  ctrl_rsv_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_addr == 2'd0) |=> (bus_rdata[BUS_W-1:4] == '0));
  // R3
  done_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && mode == 2'b00) |=> flag_q);
  // R4
  below_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && mode == 2'b01 && $signed(conv_result) < $signed(thr)) |=> flag_q);
  // R5
  above_sets_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && mode == 2'b11 && $signed(conv_result) > $signed(thr)) |=> flag_q);
  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!conv_done && !vec_ack && !wr_one) |=> $stable(flag_q));
  // R7
  rsvd_no_set_chk: assert property (@(posedge clk) disable iff (rst)
    (mode == 2'b10 && !flag_q) |=> !flag_q);
  // R8
  w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (wr_one && !conv_done) |=> !flag_q);
  // R9
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (vec_ack && !conv_done) |=> !flag_q);
  // R12
  irq_track_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req == ($past(flag_q) && ($past(lvl) != '0)) && irq_lvl == $past(lvl)));
endmodule

bind adc_cmp_irq adc_cmp_irq_chk #(.DATA_W(DATA_W), .BUS_W(BUS_W), .LVL_W(LVL_W)) u_chk (
  .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .bus_rdata(bus_rdata), .conv_done(conv_done), .conv_result(conv_result),
  .vec_ack(vec_ack), .irq_req(irq_req), .irq_lvl(irq_lvl), .mode(mode),
  .lvl(lvl), .thr(thr), .flag_q(flag_q)
);

// File: tb/sim_adc_cmp_irq.sv
module sim_adc_cmp_irq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        conv_done = 1'b0;
  logic [11:0] conv_result = '0;
  logic        vec_ack = 1'b0;
  logic        irq_req;
  logic [1:0]  irq_lvl;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  adc_cmp_irq u0 (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_done(conv_done),
    .conv_result(conv_result), .vec_ack(vec_ack), .irq_req(irq_req),
    .irq_lvl(irq_lvl)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000 && !done) begin
      done = 1'b1;
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    step();
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    bus_addr = a;
    step();
    v = int'(bus_rdata);
  endtask

  task automatic set_thr(input int t);
    wr(2'd2, t[7:0]);
    wr(2'd3, {4'b0, t[11:8]});
  endtask

  task automatic conv(input int r);
    conv_result = r[11:0]; conv_done = 1'b1;
    step();
    conv_done = 1'b0;
  endtask

  function automatic int expect_set(input int m, input int r, input int t);
    case (m)
      0: return 1;
      1: return (r < t) ? 1 : 0;
      3: return (r > t) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  initial begin
    int v;
    int thr_list[6] = '{-2048, -1, 0, 1, 100, 2047};
    repeat (3) step();
    rst = 1'b0;
    // R1 reset values
    chk("R1 irq_req", int'(irq_req), 0);
    chk("R1 irq_lvl", int'(irq_lvl), 0);
    rd(2'd0, v); chk("R1 ctrl", v, 0);
    rd(2'd1, v); chk("R1 flag", v, 0);
    rd(2'd2, v); chk("R1 thrlo", v, 0);
    rd(2'd3, v); chk("R1 thrhi", v, 0);

    // R2 control layout and reserved bits
    wr(2'd0, 8'hFD);
    rd(2'd0, v); chk("R2 ctrl readback", v, 8'h0D);
    chk("R12 irq_lvl follows level", int'(irq_lvl), 1);

    // R11 staged low byte, atomic commit
    wr(2'd0, 8'h04);               // mode 01, level 0
    wr(2'd2, 8'h50);
    rd(2'd2, v); chk("R11 low not committed", v, 0);
    conv(16);
    rd(2'd1, v); chk("R11 compare uses old threshold", v, 0);
    wr(2'd3, 8'hF0);
    rd(2'd2, v); chk("R11 low committed", v, 8'h50);
    rd(2'd3, v); chk("R11 high read", v, 0);
    conv(16);
    rd(2'd1, v); chk("R11 compare uses new threshold", v, 1);
    wr(2'd1, 8'h01);

    // Sweep over modes, thresholds and results
    for (int m = 0; m < 4; m++) begin
      for (int ti = 0; ti < 6; ti++) begin
        int t = thr_list[ti];
        int l = (m + ti) % 4;
        wr(2'd0, 8'((m << 2) | l));
        set_thr(t);
        for (int k = -3; k < 104; k++) begin
          int r;
          int e;
          if (k < 0) r = t + k + 2;
          else r = -2048 + k * 39;
          if (r < -2048) r = -2048;
          if (r > 2047) r = 2047;
          e = expect_set(m, r, t);
          conv(r);
          rd(2'd1, v);
          case (m)
            0: chk("R3 done mode flag", v, e);
            1: chk("R4 below mode flag", v, e);
            2: chk("R7 reserved mode flag", v, e);
            default: chk("R5 above mode flag", v, e);
          endcase
          chk("R12 irq_req", int'(irq_req), (e == 1 && l != 0) ? 1 : 0);
          chk("R13 flag bits 7:1 zero", v >> 1, 0);
          wr(2'd1, 8'h01);
          rd(2'd1, v);
          chk("R8 write one clears", v, 0);
        end
      end
    end

    // R6 miss leaves a set flag set; R8 write zero no effect
    wr(2'd0, 8'h01);
    conv(5);
    wr(2'd0, 8'h05);               // mode 01, threshold 2047 from sweep tail
    set_thr(0);
    conv(5);
    rd(2'd1, v); chk("R6 miss keeps flag", v, 1);
    repeat (4) step();
    rd(2'd1, v); chk("R6 idle keeps flag", v, 1);
    wr(2'd1, 8'hFE);
    rd(2'd1, v); chk("R8 write zero no effect", v, 1);

    // R9 acknowledge clears
    vec_ack = 1'b1; step(); vec_ack = 1'b0;
    rd(2'd1, v); chk("R9 ack clears", v, 0);

    // R10 set wins over clear
    wr(2'd0, 8'h01);               // mode 00
    conv(0);
    bus_addr = 2'd1; bus_wdata = 8'h01; bus_wr = 1'b1;
    conv_result = '0; conv_done = 1'b1;
    step();
    bus_wr = 1'b0; conv_done = 1'b0;
    rd(2'd1, v); chk("R10 set beats write-one", v, 1);
    vec_ack = 1'b1; conv_done = 1'b1;
    step();
    vec_ack = 1'b0; conv_done = 1'b0;
    rd(2'd1, v); chk("R10 set beats ack", v, 1);
    chk("R12 irq with level 1", int'(irq_req), 1);
    wr(2'd0, 8'h00);
    step();
    chk("R12 level zero masks request", int'(irq_req), 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule